// File: doc/BRIEF.md
# I2C Target Receive Queue with ACK Policy

This block is the receive half of an I2C target. A bit-level engine, which is not part of this block, handles bus timing, START/STOP and address comparison. It hands this block two kinds of single-cycle strobes: a notice that the target was addressed for a master write, and a notice that a data byte has been received. For each strobe the block answers in the same cycle with an acknowledge decision. The decision is based on how full its byte queue is and on a software policy bit. Accepted bytes go into an 8-entry first-in first-out store. Software drains the store through a small register port.

Software sets a fill threshold. A status bit reports whenever the stored byte count is at or above that threshold. A self-clearing command discards everything in the store. A byte that arrives when the store is full is dropped and raises a sticky overflow flag. That flag reaches the interrupt line only when its enable is set.

The register port has four 8-bit locations. Each location is selected by a 2-bit address. Writes take effect at the clock edge. Reads are combinational, and reading the data location removes the head byte at the clock edge.

Top module: `i2c_tgt_rx_fifo`

## Requirements
- R1: The store holds up to 8 bytes in arrival order. Location 3 reads 8 (the store depth). Reading location 2 returns the head byte, or 0 when the store is empty, and a read with `reg_rd`=1 removes that byte at the clock edge. A removal from an empty store does nothing.
- R2: Location 1 bit 0 is 1 exactly when the stored count is greater than or equal to the threshold in location 0 bits [3:0]. A threshold of 0 always gives 1, a threshold of 8 gives 1 only when full, and a threshold above 8 never gives 1. Location 1 also reports: bit 2 empty, bit 3 full, and bits [7:4] the count.
- R3: Writing location 0 with bit 4 = 1 sets the flush bit. The flush bit reads 1 for the next cycle only. At the end of that cycle the store becomes empty, and any byte or removal in that cycle is discarded. Writing bit 4 = 0 does not flush.
- R4: When an address match arrives, `adr_ack` is 0 if the store is non-empty and the no-respond bit (location 0 bit 5) is 1. Otherwise `adr_ack` is 1.
- R5: If the store is non-empty at an address match, every data byte until the next address match is answered with `data_ack`=0 and is not stored.
- R6: If the store was empty at the last address match, each byte is answered with `data_ack`=1 and stored while space remains. A byte that arrives while the store is full gets `data_ack`=0.
- R7: A byte that is not refused under R5 and that arrives while the store is full sets the overflow flag (location 1 bit 1). The flag stays set until software writes 1 to location 1 bit 1. If a new overflow occurs in the same cycle as that write, the flag stays set.
- R8: `irq` equals the overflow flag AND the interrupt enable (location 0 bit 6).
- R9: After reset, all control fields, the overflow flag, the flush bit, the count and `irq` are 0, and the store is empty.
- R10: A byte stored in the same cycle as a head removal leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adr_match | input | 1 | Strobe: addressed for a master write |
| byte_valid | input | 1 | Strobe: data byte received |
| byte_data | input | 8 | Received byte |
| adr_ack | output | 1 | Address-phase answer, 1 = ACK |
| data_ack | output | 1 | Data-phase answer, 1 = ACK |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on location 2) |
| reg_addr | input | 2 | Register location |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Overflow interrupt |

## Verification
The queue is tested with several input patterns:
- Bursts that fill it to capacity and beyond. These separate the refuse-when-full path from the overflow flag.
- Interleaved stores and reads. These expose any error in ordering and in the count when a store and a read share a cycle.
- Address matches made with an empty store and with a non-empty store, under both policy settings. These tell the address refusal apart from the data refusal.

Threshold values of 0, an intermediate level, 8 and 9 are swept against changing fill levels to test the greater-or-equal comparison at its ends. A flush is issued with a byte arriving in the flush cycle, to confirm that the byte is discarded.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned REG_W  = 8;

  typedef enum logic [1:0] {
    LOC_CTRL = 2'd0,
    LOC_STAT = 2'd1,
    LOC_DATA = 2'd2,
    LOC_SIZE = 2'd3
  } loc_e;

  // control layout inside location 0
  localparam int unsigned CTRL_FLUSH_BIT = 4;
  localparam int unsigned CTRL_NORESP_BIT = 5;
  localparam int unsigned CTRL_IE_BIT = 6;
  // status layout inside location 1
  localparam int unsigned STAT_OVF_BIT = 1;

  function automatic logic level_reached(input int unsigned fill, input int unsigned level);
    return fill >= level;
  endfunction

  function automatic int unsigned ptr_advance(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/i2c_rx_store.sv
module i2c_rx_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_go,
  input  logic             push_en,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_req,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  import i2c_rx_pkg::*;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             pop_en;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign pop_en = pop_req && !empty && !flush_go;
  assign head   = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_en) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush_go) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_en) wr_ptr <= PTR_W'(ptr_advance(int'(wr_ptr), DEPTH));
      if (pop_en)  rd_ptr <= PTR_W'(ptr_advance(int'(rd_ptr), DEPTH));
      case ({push_en, pop_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  assert_push_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> !full);
  assert_flush_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_go |=> empty);
  assert_pushpop_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && pop_en) |=> count == $past(count));
endmodule

// File: rtl/i2c_rx_respond.sv
module i2c_rx_respond (
  input  logic clk,
  input  logic rst_n,
  input  logic adr_match,
  input  logic byte_valid,
  input  logic no_resp,
  input  logic empty,
  input  logic full,
  input  logic flush_go,
  output logic adr_ack,
  output logic data_ack,
  output logic push_en,
  output logic overflow_evt
);
  // refuse_q: data of the current write transfer is being refused
  logic refuse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         refuse_q <= 1'b0;
    else if (adr_match) refuse_q <= !empty;
  end

  assign adr_ack      = !(no_resp && !empty);
  assign data_ack     = !refuse_q && !full;
  assign push_en      = byte_valid && data_ack && !flush_go;
  assign overflow_evt = byte_valid && !refuse_q && full;

  assert_busy_data_nack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_match && !empty) ##1 (byte_valid && !adr_match) |-> !push_en && !data_ack);
  assert_idle_adr_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_match && empty) |-> adr_ack);
endmodule

// File: rtl/i2c_rx_regs.sv
module i2c_rx_regs #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned THR_W = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  input  logic [7:0]       head,
  input  logic [CNT_W-1:0] count,
  input  logic             empty,
  input  logic             full,
  input  logic             overflow_evt,
  output logic             flush_go,
  output logic             no_resp,
  output logic             pop_req,
  output logic             irq,
  output logic [7:0]       reg_rdata
);
  import i2c_rx_pkg::*;

  logic [THR_W-1:0] thr_q;
  logic             flush_q, noresp_q, ie_q, ovf_q;
  logic             ctrl_wr, stat_wr, ovf_clr, thr_hit;

  assign ctrl_wr = reg_wr && (reg_addr == LOC_CTRL);
  assign stat_wr = reg_wr && (reg_addr == LOC_STAT);
  assign ovf_clr = stat_wr && reg_wdata[STAT_OVF_BIT];
  assign pop_req = reg_rd && (reg_addr == LOC_DATA);
  assign thr_hit = level_reached(int'(count), int'(thr_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q    <= '0;
      flush_q  <= 1'b0;
      noresp_q <= 1'b0;
      ie_q     <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      flush_q <= ctrl_wr && reg_wdata[CTRL_FLUSH_BIT];
      if (ctrl_wr) begin
        thr_q    <= reg_wdata[THR_W-1:0];
        noresp_q <= reg_wdata[CTRL_NORESP_BIT];
        ie_q     <= reg_wdata[CTRL_IE_BIT];
      end
      if (overflow_evt) ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  assign flush_go = flush_q;
  assign no_resp  = noresp_q;
  assign irq      = ovf_q && ie_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      LOC_CTRL: begin
        reg_rdata[THR_W-1:0]       = thr_q;
        reg_rdata[CTRL_FLUSH_BIT]  = flush_q;
        reg_rdata[CTRL_NORESP_BIT] = noresp_q;
        reg_rdata[CTRL_IE_BIT]     = ie_q;
      end
      LOC_STAT: begin
        reg_rdata[0]            = thr_hit;
        reg_rdata[STAT_OVF_BIT] = ovf_q;
        reg_rdata[2]            = empty;
        reg_rdata[3]            = full;
        reg_rdata[7:4]          = 4'(count);
      end
      LOC_DATA: reg_rdata = head;
      default:  reg_rdata = 8'(DEPTH);
    endcase
  end

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
  assert_ovf_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_evt |=> ovf_q);
  assert_flush_self_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_q && !(ctrl_wr && reg_wdata[CTRL_FLUSH_BIT])) |=> !flush_q);
  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(overflow_evt) || $past(ctrl_wr));
  assert_thr_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q == '0) |-> thr_hit);
endmodule

// File: rtl/i2c_tgt_rx_fifo.sv
module i2c_tgt_rx_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned THR_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adr_match,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  output logic       adr_ack,
  output logic       data_ack,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             flush_go, no_resp, pop_req;
  logic             push_en, overflow_evt;
  logic             empty, full;
  logic [7:0]       head;
  logic [CNT_W-1:0] count;

  i2c_rx_store #(.DEPTH(DEPTH), .WIDTH(8)) store_i (
    .clk(clk), .rst_n(rst_n), .flush_go(flush_go), .push_en(push_en),
    .push_data(byte_data), .pop_req(pop_req), .head(head), .count(count),
    .empty(empty), .full(full)
  );

  i2c_rx_respond respond_i (
    .clk(clk), .rst_n(rst_n), .adr_match(adr_match), .byte_valid(byte_valid),
    .no_resp(no_resp), .empty(empty), .full(full), .flush_go(flush_go),
    .adr_ack(adr_ack), .data_ack(data_ack), .push_en(push_en),
    .overflow_evt(overflow_evt)
  );

  i2c_rx_regs #(.DEPTH(DEPTH), .THR_W(THR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .head(head), .count(count),
    .empty(empty), .full(full), .overflow_evt(overflow_evt),
    .flush_go(flush_go), .no_resp(no_resp), .pop_req(pop_req), .irq(irq),
    .reg_rdata(reg_rdata)
  );

  assert_nack_keeps_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !data_ack) |=> count <= $past(count));
endmodule

// File: tb/i2c_tgt_rx_fifo_tb.sv
module i2c_tgt_rx_fifo_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       adr_match = 0, byte_valid = 0, reg_wr = 0, reg_rd = 0;
  logic [7:0] byte_data = 0, reg_wdata = 0;
  logic [1:0] reg_addr = 0;
  logic       adr_ack, data_ack, irq;
  logic [7:0] reg_rdata;

  int checks = 0;
  int errors = 0;

  // reference model state
  byte unsigned q[$];
  int  m_thr = 0;
  bit  m_flush = 0, m_noresp = 0, m_ie = 0, m_ovf = 0, m_refuse = 0;

  always #2 clk = ~clk;

  i2c_tgt_rx_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .adr_match(adr_match), .byte_valid(byte_valid),
    .byte_data(byte_data), .adr_ack(adr_ack), .data_ack(data_ack),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rdata(input int a);
    int v = 0;
    int n = q.size();
    case (a)
      0: v = m_thr | (int'(m_flush) << 4) | (int'(m_noresp) << 5) | (int'(m_ie) << 6);
      1: v = int'(n >= m_thr) | (int'(m_ovf) << 1) | (int'(n == 0) << 2)
             | (int'(n == 8) << 3) | (n << 4);
      2: v = (n == 0) ? 0 : int'(q[0]);
      default: v = 8;
    endcase
    return v;
  endfunction

  // one clock: drive, compare combinational outputs, then advance the model
  task automatic step(input bit am, input bit bv, input int bd, input bit wr, input bit rd,
                      input int a, input int wd, input string tag);
    bit e_aack, e_dack, ovf_evt;
    int n;
    @(negedge clk);
    adr_match = am; byte_valid = bv; byte_data = 8'(bd);
    reg_wr = wr; reg_rd = rd; reg_addr = 2'(a); reg_wdata = 8'(wd);
    #1;
    n = q.size();
    e_aack = !(n != 0 && m_noresp);
    e_dack = !m_refuse && n < 8;
    chk(adr_ack == e_aack, "R4 adr_ack", adr_ack, e_aack);
    chk(data_ack == e_dack, "R5/R6 data_ack", data_ack, e_dack);
    chk(irq == (m_ovf && m_ie), "R8 irq", irq, m_ovf && m_ie);
    chk(reg_rdata == 8'(exp_rdata(a)), tag, reg_rdata, exp_rdata(a));
    @(posedge clk);
    ovf_evt = bv && !m_refuse && n == 8;
    if (m_flush) q.delete();
    else begin
      if (rd && a == 2 && n > 0) void'(q.pop_front());
      if (bv && e_dack) q.push_back(byte'(bd));
    end
    if (am) m_refuse = (n != 0);
    if (ovf_evt) m_ovf = 1;
    else if (wr && a == 1 && wd[1]) m_ovf = 0;
    m_flush = wr && a == 0 && wd[4];
    if (wr && a == 0) begin
      m_thr = wd & 15; m_noresp = wd[5]; m_ie = wd[6];
    end
  endtask

  task automatic idle(input int a, input string tag);
    step(0, 0, 0, 0, 0, a, 0, tag);
  endtask
  task automatic put(input int d);
    step(0, 1, d, 0, 0, 1, 0, "R6 status after byte");
  endtask
  task automatic wctrl(input int wd);
    step(0, 0, 0, 1, 0, 0, wd, "R3 ctrl write");
  endtask
  task automatic pop(input string tag);
    step(0, 0, 0, 0, 1, 2, 0, tag);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R9 reset state
    idle(0, "R9 ctrl reset");
    idle(1, "R9 status reset");
    idle(2, "R9 data reset");
    idle(3, "R1 size reads 8");
    // R2 threshold 2 with rising fill
    wctrl(2);
    step(1, 0, 0, 0, 0, 1, 0, "R4 address on empty");
    put(8'h11); put(8'h22); put(8'h33);
    idle(1, "R2 threshold 2 with 3 bytes");
    // R1 ordering and pops
    pop("R1 head 0x11"); pop("R1 head 0x22");
    // R10 store and removal together
    step(0, 1, 8'h44, 0, 1, 2, 0, "R10 push with pop");
    idle(1, "R10 count unchanged");
    pop("R1 head 0x44"); pop("R1 pop empty");
    idle(2, "R1 empty data reads 0");
    // R6 fill to full, then overflow R7
    wctrl(8);
    for (int i = 0; i < 8; i++) put(8'hA0 + i);
    idle(1, "R2 threshold 8 full");
    put(8'hEE);
    idle(1, "R7 overflow flag set");
    wctrl(8 | 64);
    idle(1, "R8 irq with enable");
    step(0, 1, 8'hEF, 1, 0, 1, 2, "R7 set wins over clear");
    idle(1, "R7 still set");
    step(0, 0, 0, 1, 0, 1, 2, "R7 clear write");
    idle(1, "R7 cleared");
    wctrl(9);
    idle(1, "R2 threshold 9 never");
    // R5 refusal with non-empty store, ack mode
    wctrl(0);
    step(1, 0, 0, 0, 0, 1, 0, "R4 address ack with data present");
    pop("R5 drain one");
    put(8'h55); put(8'h56);
    idle(1, "R5 refused bytes not stored");
    // R4 no-respond mode
    wctrl(32 | 3);
    step(1, 0, 0, 0, 0, 1, 0, "R4 address nack");
    // R3 flush with byte in the flush cycle
    wctrl(16 | 3);
    step(0, 1, 8'h77, 0, 1, 0, 0, "R3 flush bit reads 1");
    idle(0, "R3 flush bit self-cleared");
    idle(1, "R3 store emptied");
    wctrl(0);
    idle(1, "R3 write 0 no flush");
    step(1, 0, 0, 0, 0, 1, 0, "R6 address on empty again");
    put(8'h90); put(8'h91);
    wctrl(0);
    idle(1, "R3 bit4 zero keeps bytes");
    pop("R1 head 0x90"); pop("R1 head 0x91");
    idle(1, "R2 threshold 0 on empty");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule